// File: doc/BRIEF.md
# Line-Follower Forward-Drive Decision

This block decides, once per clock, whether a small line-tracking robot may drive forward. It takes one obstacle flag and three downward-looking line sensors (left, middle, right). The line sensors read low when they see the dark track and high over the light floor, while the obstacle flag reads high when something blocks the path. The result is a single drive-enable bit.

The robot is allowed to advance only with a clear path and the middle sensor on the track, with at most one of the two side sensors also on the track. If both side sensors see the track together with the middle, or if the middle sensor is off the track, the robot halts. The decision is computed combinationally and captured in a flip-flop on the rising clock edge, with a synchronous reset that forces a halt. Sensor inputs are taken as already synchronous to the clock; no filtering is done.

Top module: `line_follow_drive`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `drive_fwd_o` is 0 after that edge, whatever the sensor inputs are.
- R2: `drive_fwd_o` changes only at rising edges of `clk`; after an edge with `rst` low it equals the decision for the inputs present at that edge, and it holds that value until the next edge.
- R3: With `obstacle_i` = 1 (path blocked), `drive_fwd_o` is 0 after the next edge, for every line-sensor pattern.
- R4: With `line_mid_i` = 1 (middle sensor over the light floor), `drive_fwd_o` is 0 after the next edge, for every other input value.
- R5: With `obstacle_i` = 0, `line_mid_i` = 0 and both `line_left_i` and `line_right_i` = 1 (only the middle sensor on the track), `drive_fwd_o` is 1 after the next edge.
- R6: With `obstacle_i` = 0, `line_mid_i` = 0 and exactly one of `line_left_i`, `line_right_i` = 0, `drive_fwd_o` is 1 after the next edge.
- R7: With `obstacle_i` = 0 and all three line inputs = 0 (all sensors on the track), `drive_fwd_o` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; forces a halt |
| obstacle_i | input | 1 | 1 = path blocked, 0 = path clear |
| line_left_i | input | 1 | Left line sensor, 0 = track seen, 1 = floor seen |
| line_mid_i | input | 1 | Middle line sensor, 0 = track seen, 1 = floor seen |
| line_right_i | input | 1 | Right line sensor, 0 = track seen, 1 = floor seen |
| drive_fwd_o | output | 1 | 1 = drive forward, 0 = halt (registered) |

## Verification
The bench builds the block with its default parameters: line sensors active low, obstacle flag active high and a halt as the reset value, which is the polarity set the requirements are written for. With those values all sixteen combinations of the four sensor bits are within reach, so every input code is applied in turn and then again in random order, each compared one edge later against a bench-side decision table. The non-exclusive corner (middle plus both sides) and a reset asserted while the inputs ask for motion are driven directly.

// File: rtl/linefollow_pkg.sv
package linefollow_pkg;

  localparam int SIDE_COUNT = 3;

  // Per-sensor "sees the track" flags after polarity is resolved.
  typedef struct packed {
    logic left;
    logic mid;
    logic right;
  } on_track_t;

  // Forward motion: clear path, middle on track, not both sides on track.
  function automatic logic allow_forward(input logic blocked, input on_track_t s);
    return !blocked && s.mid && !(s.left && s.right);
  endfunction

endpackage

// File: rtl/lf_sense_decode.sv
module lf_sense_decode
  import linefollow_pkg::*;
#(
  parameter bit LINE_ACTIVE_LOW  = 1'b1,
  parameter bit OBST_ACTIVE_HIGH = 1'b1
) (
  input  logic                  obstacle_raw,
  input  logic [SIDE_COUNT-1:0] line_raw,      // {left, mid, right}
  output logic                  blocked,
  output on_track_t             on_track
);

  logic [SIDE_COUNT-1:0] seen;

  generate
    if (LINE_ACTIVE_LOW) begin : g_line_low
      assign seen = ~line_raw;
    end else begin : g_line_high
      assign seen = line_raw;
    end

    if (OBST_ACTIVE_HIGH) begin : g_obst_high
      assign blocked = obstacle_raw;
    end else begin : g_obst_low
      assign blocked = ~obstacle_raw;
    end
  endgenerate

  assign on_track.left  = seen[2];
  assign on_track.mid   = seen[1];
  assign on_track.right = seen[0];

endmodule

// File: rtl/lf_motion_rule.sv
module lf_motion_rule
  import linefollow_pkg::*;
(
  input  logic      blocked,
  input  on_track_t on_track,
  output logic      move_now,
  output logic      mid_lost,
  output logic      sides_both
);

  assign mid_lost   = !on_track.mid;
  assign sides_both = on_track.left && on_track.right;
  assign move_now   = allow_forward(blocked, on_track);

endmodule

// File: rtl/lf_drive_reg.sv
module lf_drive_reg #(
  parameter bit HALT_VALUE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= HALT_VALUE;
    else     q <= d;
  end

endmodule

// File: rtl/line_follow_drive.sv
module line_follow_drive
  import linefollow_pkg::*;
#(
  parameter bit LINE_ACTIVE_LOW  = 1'b1,
  parameter bit OBST_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic obstacle_i,
  input  logic line_left_i,
  input  logic line_mid_i,
  input  logic line_right_i,
  output logic drive_fwd_o
);

  logic      blocked;
  on_track_t on_track;
  logic      move_now;
  logic      mid_lost;
  logic      sides_both;

  lf_sense_decode #(
    .LINE_ACTIVE_LOW (LINE_ACTIVE_LOW),
    .OBST_ACTIVE_HIGH(OBST_ACTIVE_HIGH)
  ) u_decode (
    .obstacle_raw(obstacle_i),
    .line_raw    ({line_left_i, line_mid_i, line_right_i}),
    .blocked     (blocked),
    .on_track    (on_track)
  );

  lf_motion_rule u_rule (
    .blocked   (blocked),
    .on_track  (on_track),
    .move_now  (move_now),
    .mid_lost  (mid_lost),
    .sides_both(sides_both)
  );

  lf_drive_reg #(
    .HALT_VALUE(1'b0)
  ) u_reg (
    .clk(clk),
    .rst(rst),
    .d  (move_now),
    .q  (drive_fwd_o)
  );

  AST_RESET_HALTS: assert property (@(posedge clk) rst |=> !drive_fwd_o); // R1

  AST_REG_TRACKS_RULE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> drive_fwd_o == $past(move_now)); // R2

  AST_BLOCKED_HALTS: assert property (@(posedge clk) disable iff (rst)
    $past(blocked) |-> !drive_fwd_o); // R3

  AST_MID_LOST_HALTS: assert property (@(posedge clk) disable iff (rst)
    $past(mid_lost) |-> !drive_fwd_o); // R4

  AST_MID_ONLY_MOVES: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !blocked && on_track.mid && !on_track.left && !on_track.right))
    |-> drive_fwd_o); // R5

  AST_ONE_SIDE_MOVES: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !blocked && on_track.mid && (on_track.left != on_track.right)))
    |-> drive_fwd_o); // R6

  AST_ALL_ON_HALTS: assert property (@(posedge clk) disable iff (rst)
    $past(sides_both) |-> !drive_fwd_o); // R7

endmodule

// File: tb/line_follow_drive_bench.sv
module line_follow_drive_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic obstacle_i = 1'b0;
  logic line_left_i = 1'b1;
  logic line_mid_i = 1'b1;
  logic line_right_i = 1'b1;
  logic drive_fwd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_follow_drive u_line_follow_drive (
    .clk         (clk),
    .rst         (rst),
    .obstacle_i  (obstacle_i),
    .line_left_i (line_left_i),
    .line_mid_i  (line_mid_i),
    .line_right_i(line_right_i),
    .drive_fwd_o (drive_fwd_o)
  );

  // Code layout {obstacle, left, mid, right}. Moving codes: 1, 4, 5.
  function automatic bit ref_move(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd5: return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] code);
    if (code[3])                  return "R3";
    else if (code[1])             return "R4";
    else if (!code[2] && !code[0]) return "R7";
    else if (code[2] && code[0])  return "R5";
    else                          return "R6";
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] code);
    {obstacle_i, line_left_i, line_mid_i, line_right_i} = code;
  endtask

  // Drive at the falling edge, sample at the next falling edge.
  task automatic step_check(input logic [3:0] code);
    apply(code);
    @(negedge clk);
    check(drive_fwd_o, ref_move(code), req_of(code), $sformatf("code %0d", code));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset with a moving code on the inputs
    apply(4'd5);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(drive_fwd_o, 1'b0, "R1", "reset with move code");
    rst = 1'b0;

    // Exhaustive sweep over all sixteen codes (R3..R7)
    for (int c = 0; c < 16; c++) step_check(4'(c));

    // R7 directed: all three on the track, after a moving state
    step_check(4'd5);
    step_check(4'd0);
    // R5 directed: only middle
    step_check(4'd5);
    // R3: obstacle with otherwise moving pattern
    step_check(4'd13);

    // R2: output holds until the edge
    step_check(4'd15);
    apply(4'd4);
    #1;
    check(drive_fwd_o, 1'b0, "R2", "no change before edge");
    @(negedge clk);
    check(drive_fwd_o, 1'b1, "R2", "updates after edge");
    apply(4'd2);
    #1;
    check(drive_fwd_o, 1'b1, "R2", "holds before edge");
    @(negedge clk);
    check(drive_fwd_o, 1'b0, "R2", "halts after edge");

    // R1: reset mid-run while moving
    step_check(4'd1);
    rst = 1'b1;
    @(negedge clk);
    check(drive_fwd_o, 1'b0, "R1", "reset mid-run");
    rst = 1'b0;
    @(negedge clk);
    check(drive_fwd_o, 1'b1, "R2", "resume after reset");

    // Random stream
    for (int i = 0; i < 300; i++) step_check(4'($urandom_range(0, 15)));

    finish_run();
  end

endmodule